// File: doc/BRIEF.md
# Priority-Class Word Arbiter for Six Transfer Channels

Six transfer channels share one address and bus datapath, and this arbiter decides which of them moves the next word. Each channel has a request line and a 2-bit priority level. The arbiter always serves the highest level that has a request pending. Channels that share that level take turns, one word each, in rising channel order that wraps around. A grant is held for a whole word and is released only when the datapath pulses word-done. A channel with a higher level that raises its request in mid-word therefore waits for that word to finish.

Each level keeps its own rotation pointer. When a higher class interrupts a rotation, the interrupted class later resumes where it stopped. The arbiter also outputs the level of the granted channel, so that an external bus arbiter can compare it against the processor's own access level. All outputs are registered.

Top module: `xfer_class_arbiter`

## Requirements
- R1: Synchronous active-high reset clears the grant, lowers `grant_valid`, drives `active_lvl` to 0 and sets every level's rotation pointer to channel 0. With all six channels requesting at one level after reset, channel 0 is served first.
- R2: `grant` is always zero or one-hot. `grant_valid` is high exactly when `grant` is nonzero, and then `grant[grant_idx]` is 1. With no request pending at an arbitration point, `grant` becomes zero and `grant_valid` becomes low.
- R3: When the arbiter is idle and any request is high at a clock edge, the grant appears on that edge and is visible in the next cycle.
- R4: Once issued, a grant is held unchanged until a cycle with `word_done` high, even if the granted channel drops its request. A new decision is registered on the edge that samples `word_done` high.
- R5: The priority of channel i is `prio[2i+1:2i]`. Value 2'b11 is the highest level and 2'b00 the lowest. At each arbitration point, only the requesting channels at the highest requesting level are eligible.
- R6: Among eligible channels at level L, the chosen channel is the first requesting one at or after level L's pointer, in rising index order with wrap from 5 to 0. The pointer then moves to the channel after the one granted.
- R7: A channel that alone holds the highest requesting level receives every successive word for as long as it keeps requesting.
- R8: A higher-level request that arrives during a word does not disturb the current grant. It is granted at the next `word_done`.
- R9: Each level has its own pointer. After a higher class has been served, rotation at a lower level continues from the channel after the last one granted at that level.
- R10: `active_lvl` equals the priority level of the granted channel as sampled at the decision. It is 0 while `grant_valid` is low.
- R11: Changes to `prio` while a grant is held have no effect on `grant` or `active_lvl` until the next arbitration point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_CH | Per-channel transfer request |
| prio | input | NUM_CH*PRIO_W | Packed per-channel priority levels, channel i at bits [PRIO_W*i +: PRIO_W] |
| word_done | input | 1 | One-cycle pulse ending the current word |
| grant | output | NUM_CH | One-hot grant, zero when idle |
| grant_idx | output | $clog2(NUM_CH) | Index of the granted channel |
| grant_valid | output | 1 | A grant is held |
| active_lvl | output | PRIO_W | Priority level of the granted channel |

## Verification
The hardest situation to reach from the ports is a resumed rotation. A rotation at a low level must be part-way through, a higher class must take over at a word boundary, and the low class must then continue from its saved place rather than from channel 0. The directed stimulus starts an all-level-0 rotation and advances it to channel 1. It then raises channel 5 to level 2 in mid-word, serves channel 5 and withdraws it, and expects channel 2 next. A long pseudo-random sweep of requests, priorities and word-done pulses then compares every cycle against an arithmetic model of the per-level pointers.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Next rotation position after index v, wrapping at n channels.
  function automatic int wrap_next(input int v, input int n);
    return (v >= n - 1) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/lvl_select.sv
module lvl_select #(
  parameter int NUM_CH = 6,
  parameter int PRIO_W = 2
) (
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] prio,
  output logic                     any_req,
  output logic [PRIO_W-1:0]        top_lvl,
  output logic [NUM_CH-1:0]        cand
);
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (prio[PRIO_W*i +: PRIO_W] > top_lvl))
        top_lvl = prio[PRIO_W*i +: PRIO_W];
    end
    for (int i = 0; i < NUM_CH; i++)
      cand[i] = req[i] && (prio[PRIO_W*i +: PRIO_W] == top_lvl);
    any_req = |req;
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM_CH = 6,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [IDX_W-1:0]  ptr,
  output logic [IDX_W-1:0]  pick,
  output logic              hit
);
  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= NUM_CH) j = j - NUM_CH;
      if (!hit && mask[j]) begin
        hit  = 1'b1;
        pick = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/rr_ptr_bank.sv
module rr_ptr_bank #(
  parameter int NUM_CH  = 6,
  parameter int NUM_LVL = 4,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic [LVL_W-1:0]         upd_lvl,
  input  logic [IDX_W-1:0]         upd_idx,
  output logic [NUM_LVL*IDX_W-1:0] ptrs
);
  import arb_pkg::*;

  logic [IDX_W-1:0] nxt;
  assign nxt = IDX_W'(wrap_next(int'(upd_idx), NUM_CH));

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [IDX_W-1:0] p_q;
    always_ff @(posedge clk) begin
      if (rst)
        p_q <= '0;
      else if (upd && (int'(upd_lvl) == l))
        p_q <= nxt;
    end
    assign ptrs[IDX_W*l +: IDX_W] = p_q;
  end
endmodule

// File: rtl/xfer_class_arbiter.sv
module xfer_class_arbiter #(
  parameter int NUM_CH = 6,
  parameter int PRIO_W = 2,
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NUM_LVL = 1 << PRIO_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] prio,
  input  logic                     word_done,
  output logic [NUM_CH-1:0]        grant,
  output logic [IDX_W-1:0]         grant_idx,
  output logic                     grant_valid,
  output logic [PRIO_W-1:0]        active_lvl
);
  logic                     any_req;
  logic [PRIO_W-1:0]        top_lvl;
  logic [NUM_CH-1:0]        cand;
  logic [NUM_LVL*IDX_W-1:0] ptrs;
  logic [IDX_W-1:0]         cur_ptr;
  logic [IDX_W-1:0]         pick;
  logic                     hit;
  logic                     arb_pt;
  logic                     take;

  lvl_select #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_lvl (
    .req(req), .prio(prio), .any_req(any_req), .top_lvl(top_lvl), .cand(cand)
  );

  assign cur_ptr = ptrs[IDX_W*top_lvl +: IDX_W];

  rr_pick #(.NUM_CH(NUM_CH)) u_pick (
    .mask(cand), .ptr(cur_ptr), .pick(pick), .hit(hit)
  );

  // Arbitrate when idle or when the current word ends.
  assign arb_pt = !grant_valid || word_done;
  assign take   = arb_pt && any_req && hit;

  rr_ptr_bank #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL)) u_ptrs (
    .clk(clk), .rst(rst), .upd(take), .upd_lvl(top_lvl),
    .upd_idx(pick), .ptrs(ptrs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant       <= '0;
      grant_idx   <= '0;
      grant_valid <= 1'b0;
      active_lvl  <= '0;
    end else if (arb_pt) begin
      if (take) begin
        grant       <= NUM_CH'(1) << pick;
        grant_idx   <= pick;
        grant_valid <= 1'b1;
        active_lvl  <= top_lvl;
      end else begin
        grant       <= '0;
        grant_valid <= 1'b0;
        active_lvl  <= '0;
      end
    end
  end
endmodule

// File: rtl/xfer_class_arbiter_chk.sv
module xfer_class_arbiter_chk #(
  parameter int NUM_CH = 6,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CH-1:0]        req,
  input logic                     word_done,
  input logic [NUM_CH-1:0]        grant,
  input logic [IDX_W-1:0]         grant_idx,
  input logic                     grant_valid,
  input logic [PRIO_W-1:0]        active_lvl
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!grant_valid && grant == '0));

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (grant_valid == (grant != '0)));

  p_index_r2: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> grant[grant_idx]);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    ((!grant_valid || word_done) && req == '0) |=> !grant_valid);

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!grant_valid && req != '0) |=> grant_valid);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !word_done) |=> ($stable(grant) && $stable(active_lvl)));

  p_lvl_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !grant_valid |-> active_lvl == '0);
endmodule

bind xfer_class_arbiter xfer_class_arbiter_chk #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .word_done(word_done), .grant(grant),
  .grant_idx(grant_idx), .grant_valid(grant_valid), .active_lvl(active_lvl)
);

// File: tb/sim_xfer_class_arbiter.sv
`timescale 1ns/1ps
module sim_xfer_class_arbiter;
  localparam int NCH = 6;
  localparam int PW  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NCH-1:0]    req = '0;
  logic [NCH*PW-1:0] prio = '0;
  logic          word_done = 1'b0;
  logic [NCH-1:0] grant;
  logic [2:0]     grant_idx;
  logic           grant_valid;
  logic [PW-1:0]  active_lvl;

  int checks = 0;
  int errors = 0;
  bit sweep_on = 0;

  always #5 clk = ~clk;

  xfer_class_arbiter u0 (
    .clk(clk), .rst(rst), .req(req), .prio(prio), .word_done(word_done),
    .grant(grant), .grant_idx(grant_idx), .grant_valid(grant_valid),
    .active_lvl(active_lvl)
  );

  // Arithmetic model of per-level rotation.
  int m_ptr [4];
  bit m_valid;
  int m_idx, m_lvl;
  int a_top, a_pick;
  bit a_any, a_found;

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 0; m_idx <= 0; m_lvl <= 0;
      for (int l = 0; l < 4; l++) m_ptr[l] <= 0;
    end else if (!m_valid || word_done) begin
      a_top = 0; a_any = 0; a_found = 0; a_pick = 0;
      for (int i = 0; i < NCH; i++)
        if (req[i]) begin
          a_any = 1;
          if (int'(prio[PW*i +: PW]) > a_top) a_top = int'(prio[PW*i +: PW]);
        end
      for (int k = 0; k < NCH; k++) begin
        int j;
        j = (m_ptr[a_top] + k) % NCH;
        if (!a_found && req[j] && int'(prio[PW*j +: PW]) == a_top) begin
          a_found = 1; a_pick = j;
        end
      end
      if (!a_any) begin
        m_valid <= 0; m_lvl <= 0;
      end else begin
        m_valid <= 1; m_idx <= a_pick; m_lvl <= a_top;
        m_ptr[a_top] <= (a_pick + 1) % NCH;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit wd);
    word_done = wd;
    @(negedge clk);
  endtask

  task automatic expect_grant(input int idx, input int lvl, input string tag);
    chk(grant_valid == 1'b1, tag, int'(grant_valid), 1);
    chk(int'(grant_idx) == idx && grant == (NCH'(1) << idx), tag, int'(grant_idx), idx);
    chk(int'(active_lvl) == lvl, tag, int'(active_lvl), lvl);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(grant == '0 && !grant_valid && active_lvl == '0, "R1 reset state", int'(grant), 0);
    step(0);
    chk(grant == '0 && !grant_valid, "R2 idle no request", int'(grant), 0);

    // Level-0 rotation, pointer starts at channel 0.
    req = 6'h3F; prio = '0;
    step(0);
    expect_grant(0, 0, "R3 R1 first grant");
    step(0); step(0);
    expect_grant(0, 0, "R4 held without word_done");
    req = 6'h3E;
    step(0);
    expect_grant(0, 0, "R4 held after request drop");
    req = 6'h3F;
    for (int k = 1; k <= 6; k++) begin
      step(1);
      expect_grant(k % 6, 0, "R6 rotation order");
    end
    word_done = 0;

    // Channel 4 alone at level 3; change lands mid-word first.
    prio[9:8] = 2'b11;
    step(0);
    expect_grant(0, 0, "R11 priority change mid-word ignored");
    step(1);
    expect_grant(4, 3, "R5 R10 highest level wins");
    step(1); step(1);
    expect_grant(4, 3, "R7 lone top channel keeps grant");

    // Preemption and resume at level 0.
    prio = '0;
    step(1);
    expect_grant(1, 0, "R6 level-0 pointer kept at 1");
    word_done = 0;
    prio[11:10] = 2'b10;
    step(0);
    expect_grant(1, 0, "R8 no preemption mid-word");
    step(1);
    expect_grant(5, 2, "R8 higher class at boundary");
    req = 6'h1F;
    step(1);
    expect_grant(2, 0, "R9 rotation resumes");

    // Release to idle, then restart.
    req = '0;
    step(1);
    chk(grant == '0 && !grant_valid && active_lvl == '0, "R2 R10 no request at boundary", int'(grant), 0);
    step(0);
    req = 6'b000100;
    step(0);
    expect_grant(2, 0, "R3 start from idle");

    // Pseudo-random sweep against the model.
    sweep_on = 1;
    lfsr = 32'hACE1_2024;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req       = lfsr[5:0] & (lfsr[13] ? 6'h3F : lfsr[19:14]);
      prio      = lfsr[31:20];
      word_done = lfsr[8] | lfsr[9];
      @(negedge clk);
      chk(grant_valid == m_valid, "R2 sweep valid", int'(grant_valid), int'(m_valid));
      if (m_valid) begin
        chk(int'(grant_idx) == m_idx && grant == (NCH'(1) << m_idx),
            "R5 R6 sweep grant", int'(grant_idx), m_idx);
        chk(int'(active_lvl) == m_lvl, "R10 sweep level", int'(active_lvl), m_lvl);
      end else begin
        chk(grant == '0, "R2 sweep idle grant", int'(grant), 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule